// File: doc/BRIEF.md
# Slow-Bus Arbiter with Delayed DMA Requests

This block decides who drives a slow peripheral bus: the PCI master path or the DMA unit. The PCI path owns the bus by default. Each DMA channel's request first goes through a qualification stage. A hardware request on a channel set to compatible mode becomes visible to the arbiter only after it has been held for a fixed number of system clocks. This guarantees a minimum latency between request and acknowledge for older slave devices. Software requests, and hardware requests on channels in fast mode, skip the delay.

While any qualified DMA request exists, the arbiter raises a hold request to the PCI side. It hands the bus to the DMA side only after hold acknowledge has been seen. When both agents compete, a two-way rotating pointer picks the winner, and after every real grant the pointer favours the other agent. Ownership moves only at transaction boundaries. If a DMA-initiated transaction ends with a retry, the DMA side keeps the bus and the hold request so that it can reissue the transaction.

Top module: `xarb_top`

## Requirements
- R1: On a channel with `compat_mode` = 1, a hardware request reaches `qual` only after it has been high for DELAY (default 8) consecutive clock edges. It shows there in the cycle after the DELAY-th edge. A request that drops before then restarts the count.
- R2: A channel's `sw_req`, or its `hw_req` when `compat_mode` = 0, shows on `qual` in the same cycle, with no delay.
- R3: While `rst` is high and in the first cycle after it: `gnt_pci` = 1, `gnt_dma` = 0, and every delay count is cleared, so `qual` and `hold_req` are 0 when the requests are low.
- R4: With no qualified DMA request, the bus stays with or returns to the PCI side (`gnt_pci` = 1), whether or not `pci_req` is high.
- R5: `hold_req` is high in every cycle in which some `qual` bit is high. `gnt_dma` rises only at the edge after a cycle in which both `hold_req` and `hold_ack` were high.
- R6: At a boundary where both sides compete (`pci_req` high, and a qualified DMA request with `hold_ack`), the side favoured by the rotation pointer wins. The pointer starts on the PCI side after reset. After any grant to a side that asked for the bus, the pointer moves to the other side. Which side raised its request first does not matter.
- R7: A boundary is a cycle with `xfer_done` high, or a cycle in which the owner has no request left. The DMA side counts as requesting while a retry is pending.
- R8: When `xfer_done` and `xfer_retry` are both high while the DMA side owns the bus, the DMA side keeps `gnt_dma` and `hold_req`, even if its requests have dropped. The rotation pointer does not move.
- R9: `hold_req` falls only once no channel is qualified and the DMA side's last transaction has ended without a retry.
- R10: `gnt_pci` and `gnt_dma` are one-hot and change only at the clock edge that follows a boundary cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | NUM_CH | Hardware DMA request per channel |
| sw_req | input | NUM_CH | Software DMA request per channel (never delayed) |
| compat_mode | input | NUM_CH | 1: compatible mode (delay applied); 0: fast mode |
| pci_req | input | 1 | PCI master path wants the bus |
| xfer_done | input | 1 | Current owner's transaction ends this cycle |
| xfer_retry | input | 1 | The ending transaction was terminated with retry |
| hold_ack | input | 1 | Hold acknowledge from the PCI side |
| hold_req | output | 1 | Hold request towards the PCI side |
| gnt_pci | output | 1 | Bus granted to the PCI master path |
| gnt_dma | output | 1 | Bus granted to the DMA unit |
| qual | output | NUM_CH | Qualified (delay-filtered) DMA request per channel |

## Verification
A stuck or mis-cleared delay count shows on `qual` within DELAY+1 cycles: as an early or late rise, or as a rise after a cancelled request. A wrong rotation pointer or ownership state shows on the grant pins at the first contended boundary. A lost retry flag shows one cycle after the retry, as a dropped `gnt_dma` or `hold_req`. The reference model is compared with `qual`, `hold_req` and both grants on every cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/xarb_pkg.sv
package xarb_pkg;

    typedef enum logic {
        OWN_PCI = 1'b0,
        OWN_DMA = 1'b1
    } owner_e;

    typedef struct packed {
        owner_e owner;   // current bus owner
        owner_e fav;     // side favoured at the next contended boundary
        logic   rty;     // DMA transaction retried, reissue pending
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{owner: OWN_PCI, fav: OWN_PCI, rty: 1'b0};

    function automatic owner_e pick_winner(input logic dma_c, input logic pci_c,
                                           input owner_e fav);
        if (dma_c && pci_c) return fav;
        if (dma_c)          return OWN_DMA;
        return OWN_PCI;
    endfunction

    function automatic owner_e other_side(input owner_e s);
        return (s == OWN_DMA) ? OWN_PCI : OWN_DMA;
    endfunction

endpackage

// File: rtl/xarb_req_qual.sv
module xarb_req_qual #(
    parameter int DELAY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_req,
    input  logic sw_req,
    input  logic compat,
    output logic qual
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LIM = CW'(DELAY);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !hw_req) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = sw_req | (hw_req & (~compat | (cnt == LIM)));

endmodule

// File: rtl/xarb_rotor.sv
module xarb_rotor
    import xarb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dma_want,
    input  logic pci_req,
    input  logic hold_ack,
    input  logic xfer_done,
    input  logic xfer_retry,
    output logic gnt_pci,
    output logic gnt_dma,
    output logic hold_req
);
    arb_state_t st, st_nx;
    logic owner_busy;
    logic dma_c;

    assign owner_busy = (st.owner == OWN_DMA) ? (dma_want | st.rty) : pci_req;
    assign dma_c      = dma_want & hold_ack;

    always_comb begin
        st_nx = st;
        if (st.owner == OWN_DMA && xfer_done && xfer_retry) begin
            st_nx.rty = 1'b1;
        end else if (xfer_done || !owner_busy) begin
            st_nx.rty   = 1'b0;
            st_nx.owner = pick_winner(dma_c, pci_req, st.fav);
            if (dma_c || pci_req) begin
                st_nx.fav = other_side(st_nx.owner);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ARB_RESET;
        else     st <= st_nx;
    end

    assign gnt_dma  = (st.owner == OWN_DMA);
    assign gnt_pci  = (st.owner == OWN_PCI);
    assign hold_req = dma_want | gnt_dma;

endmodule

// File: rtl/xarb_top.sv
module xarb_top #(
    parameter int NUM_CH = 4,
    parameter int DELAY  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hw_req,
    input  logic [NUM_CH-1:0] sw_req,
    input  logic [NUM_CH-1:0] compat_mode,
    input  logic              pci_req,
    input  logic              xfer_done,
    input  logic              xfer_retry,
    input  logic              hold_ack,
    output logic              hold_req,
    output logic              gnt_pci,
    output logic              gnt_dma,
    output logic [NUM_CH-1:0] qual
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        xarb_req_qual #(.DELAY(DELAY)) u_qual (
            .clk    (clk),
            .rst    (rst),
            .hw_req (hw_req[i]),
            .sw_req (sw_req[i]),
            .compat (compat_mode[i]),
            .qual   (qual[i])
        );
    end

    xarb_rotor u_rotor (
        .clk        (clk),
        .rst        (rst),
        .dma_want   (|qual),
        .pci_req    (pci_req),
        .hold_ack   (hold_ack),
        .xfer_done  (xfer_done),
        .xfer_retry (xfer_retry),
        .gnt_pci    (gnt_pci),
        .gnt_dma    (gnt_dma),
        .hold_req   (hold_req)
    );

endmodule

// File: rtl/xarb_checker.sv
module xarb_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] hw_req,
    input logic [NUM_CH-1:0] sw_req,
    input logic [NUM_CH-1:0] compat_mode,
    input logic              pci_req,
    input logic              xfer_done,
    input logic              xfer_retry,
    input logic              hold_ack,
    input logic              hold_req,
    input logic              gnt_pci,
    input logic              gnt_dma,
    input logic [NUM_CH-1:0] qual
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_delay_not_zero_R1: assert property (@(posedge clk) disable iff (rst)
            ($rose(hw_req[i]) && compat_mode[i] && !sw_req[i]) |-> !qual[i]);
        assert_delay_held_R1: assert property (@(posedge clk) disable iff (rst)
            (qual[i] && compat_mode[i] && !sw_req[i] && !$rose(compat_mode[i]))
                |-> $past(hw_req[i]));
        assert_fast_pass_R2: assert property (@(posedge clk) disable iff (rst)
            (!compat_mode[i] && hw_req[i]) |-> qual[i]);
    end

    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({gnt_pci, gnt_dma}) == 1);
    assert_park_pci_R4: assert property (@(posedge clk) disable iff (rst)
        (gnt_pci && !(|qual)) |=> gnt_pci);
    assert_hold_on_qual_R5: assert property (@(posedge clk) disable iff (rst)
        (|qual) |-> hold_req);
    assert_dma_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(gnt_dma) |-> $past(hold_req && hold_ack));
    assert_retry_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (gnt_dma && xfer_done && xfer_retry) |=> (gnt_dma && hold_req));
    assert_pci_no_cut_R10: assert property (@(posedge clk) disable iff (rst)
        (gnt_pci && pci_req && !xfer_done) |=> gnt_pci);
    assert_dma_no_cut_R10: assert property (@(posedge clk) disable iff (rst)
        (gnt_dma && (|qual) && !xfer_done) |=> gnt_dma);

endmodule

bind xarb_top xarb_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hw_req      (hw_req),
    .sw_req      (sw_req),
    .compat_mode (compat_mode),
    .pci_req     (pci_req),
    .xfer_done   (xfer_done),
    .xfer_retry  (xfer_retry),
    .hold_ack    (hold_ack),
    .hold_req    (hold_req),
    .gnt_pci     (gnt_pci),
    .gnt_dma     (gnt_dma),
    .qual        (qual)
);

// File: tb/xarb_top_test.sv
`timescale 1ns/1ps
module xarb_top_test;
    localparam int NCH = 4;
    localparam int DLY = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] hw_req = '0, sw_req = '0, compat_mode = '0;
    logic pci_req = 0, xfer_done = 0, xfer_retry = 0, hold_ack = 0;
    logic hold_req, gnt_pci, gnt_dma;
    logic [NCH-1:0] qual;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state (behavioural)
    int m_cnt[NCH];
    int m_owner;   // 0 = PCI, 1 = DMA
    int m_fav;     // side favoured at next contention
    int m_rty;

    always #5 clk = ~clk;

    xarb_top #(.NUM_CH(NCH), .DELAY(DLY)) uut (
        .clk(clk), .rst(rst), .hw_req(hw_req), .sw_req(sw_req),
        .compat_mode(compat_mode), .pci_req(pci_req), .xfer_done(xfer_done),
        .xfer_retry(xfer_retry), .hold_ack(hold_ack), .hold_req(hold_req),
        .gnt_pci(gnt_pci), .gnt_dma(gnt_dma), .qual(qual)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    function automatic logic m_qual(input int i);
        if (sw_req[i]) return 1'b1;
        if (!hw_req[i]) return 1'b0;
        return compat_mode[i] ? (m_cnt[i] >= DLY) : 1'b1;
    endfunction

    function automatic logic m_want();
        for (int i = 0; i < NCH; i++) if (m_qual(i)) return 1'b1;
        return 1'b0;
    endfunction

    // one clock: compare, then advance the model with the held inputs
    task automatic step();
        logic dw, busy, dc;
        int w;
        #1;
        if (!rst) begin
            for (int i = 0; i < NCH; i++)
                check(compat_mode[i] ? "R1 qual" : "R2 qual", qual[i], m_qual(i));
            check("R5_R9 hold_req", hold_req, m_want() | (m_owner == 1));
            check("R6_R10 gnt_dma", gnt_dma, m_owner == 1);
            check("R4_R10 gnt_pci", gnt_pci, m_owner == 0);
        end
        dw = m_want();
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
            m_owner = 0; m_fav = 0; m_rty = 0;
        end else begin
            for (int i = 0; i < NCH; i++)
                m_cnt[i] = hw_req[i] ? ((m_cnt[i] < DLY) ? m_cnt[i] + 1 : DLY) : 0;
            busy = (m_owner == 1) ? (dw | (m_rty != 0)) : pci_req;
            if (m_owner == 1 && xfer_done && xfer_retry) begin
                m_rty = 1;
            end else if (xfer_done || !busy) begin
                m_rty = 0;
                dc = dw & hold_ack;
                if (dc && pci_req) w = m_fav;
                else if (dc) w = 1;
                else w = 0;
                if (dc || pci_req) m_fav = 1 - w;
                m_owner = w;
            end
        end
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        hw_req = '0; sw_req = '0; compat_mode = '0;
        pci_req = 0; xfer_done = 0; xfer_retry = 0; hold_ack = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R3: reset with a pending compatible request
        rst = 1; hw_req[0] = 1; compat_mode = '1;
        repeat (3) step();
        rst = 0; hw_req = '0;
        #1;
        check("R3 gnt_pci", gnt_pci, 1'b1);
        check("R3 gnt_dma", gnt_dma, 1'b0);
        check("R3 hold_req", hold_req, 1'b0);
        check("R3 qual", |qual, 1'b0);
        step();

        // R4: PCI keeps bus with or without its request
        pci_req = 1; step(); step();
        pci_req = 0; step();
        check("R4 park", gnt_pci, 1'b1);

        // R1: cancel after 5 cycles, then full delay
        hw_req[0] = 1;
        repeat (5) step();
        check("R1 early", qual[0], 1'b0);
        hw_req[0] = 0; step();
        hw_req[0] = 1;
        repeat (DLY - 1) step();
        check("R1 one short", qual[0], 1'b0);
        step();
        check("R1 delay met", qual[0], 1'b1);
        // R5: no grant without acknowledge
        step(); step();
        check("R5 hold raised", hold_req, 1'b1);
        check("R5 no ack no grant", gnt_dma, 1'b0);
        hold_ack = 1; step();
        check("R5 grant after ack", gnt_dma, 1'b1);

        // R6 / R7 / R10: contention
        pci_req = 1; step();
        check("R10 no mid-transfer switch", gnt_dma, 1'b1);
        xfer_done = 1; step();
        check("R6 rotate to pci", gnt_pci, 1'b1);
        xfer_done = 0; step(); step();
        check("R7 pci holds while busy", gnt_pci, 1'b1);
        xfer_done = 1; step();
        check("R6 rotate to dma", gnt_dma, 1'b1);

        // R8 / R9: retry keeps hold and grant
        hw_req[0] = 0; xfer_retry = 1; step();
        check("R8 grant kept", gnt_dma, 1'b1);
        check("R8 hold kept", hold_req, 1'b1);
        xfer_done = 0; xfer_retry = 0; step();
        check("R8 reissue holds bus", gnt_dma, 1'b1);
        xfer_done = 1; step();
        check("R9 released", gnt_pci, 1'b1);
        check("R9 hold dropped", hold_req, 1'b0);
        xfer_done = 0; pci_req = 0; step();

        // R2: fast mode and software requests
        compat_mode[1] = 0; hw_req[1] = 1; #1;
        check("R2 fast hw", qual[1], 1'b1);
        step();
        hw_req[1] = 0; compat_mode[2] = 1; sw_req[2] = 1; #1;
        check("R2 sw bypass", qual[2], 1'b1);
        step();
        clear_inputs(); step(); step();

        // mixed traffic, model compared every cycle
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NCH; i++) begin
                if ($urandom_range(15) == 0) hw_req[i] = ~hw_req[i];
                if ($urandom_range(63) == 0) compat_mode[i] = ~compat_mode[i];
                sw_req[i] = ($urandom_range(40) == 0);
            end
            if ($urandom_range(7) == 0) pci_req = ~pci_req;
            if ($urandom_range(5) == 0) hold_ack = ~hold_ack;
            xfer_done  = ($urandom_range(3) == 0);
            xfer_retry = xfer_done && ($urandom_range(2) == 0);
            step();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule